// File: doc/BRIEF.md
# One-Time-Programmable Fuse Read Sequencer with Shadow Copy

This block reads bytes out of a one-time-programmable fuse array by driving the array's control pins (active-low select, load, active-low program enable, strobe) and its 10-bit address pins through a fixed, timed handshake. Every guard interval is a whole number of microseconds. One parameter, `CYCLES_PER_US`, converts microseconds into clock cycles, so the same RTL serves any clock frequency.

Right after reset the block runs one read session over fuse addresses 0 to 31 and stores the result in a 32-byte on-chip shadow file. When that session ends it raises `shadow_valid`. From the shadow file it drives a version byte and a leakage-trim value chosen by a two-bit channel index. These outputs let the rest of the chip read calibration data without touching the fuse array again.

After the boot read, a single-byte request interface reads any fuse address on demand. The requester holds the request until a one-cycle acknowledge returns the byte. Requests that arrive before the boot read ends wait until it completes.

Top module: `fuse_shadow_reader`

## Requirements
- R1: While in reset and while idle, the pins rest as follows: `fuse_sel_n`=1, `fuse_load`=0, `fuse_strobe`=0, `fuse_pgm_n`=1 (programming never enabled) and `fuse_addr`=0. During and right after reset, `shadow_valid`=0 and `req_ack`=0.
- R2: A session opens when `fuse_sel_n` falls with `fuse_load` high. The first strobe rises exactly 4*CYCLES_PER_US cycles later: 2 us of setup, then 2 us with the address presented. `fuse_strobe` is only ever high while `fuse_sel_n`=0 and `fuse_load`=1.
- R3: Each strobe stays high for exactly 2*CYCLES_PER_US cycles, and the address does not change while it is high. The byte is taken from `fuse_dout` in the last strobe cycle. Within a session, each strobe uses the previous address plus one and rises exactly 4*CYCLES_PER_US cycles after the previous strobe fell.
- R4: After the last strobe of a session falls, `fuse_sel_n` rises exactly 4*CYCLES_PER_US cycles later. The session ends 1 us (CYCLES_PER_US cycles) after that.
- R5: After reset the block reads fuse addresses 0 to 31, in that order, in one session, and stores byte k in shadow entry k. `shadow_valid` rises 197*CYCLES_PER_US cycles after that session's `fuse_sel_n` fall and never falls again until reset.
- R6: `version` equals shadow entry 4 with bit 3 forced to 0.
- R7: `leak_trim` equals shadow entry 23, 24 or 25 when `leak_sel` is 0, 1 or 2, and equals 0 when `leak_sel` is 3.
- R8: A request is `req_valid`=1 with `req_addr` held until acknowledged. It runs a one-byte session. `req_ack` pulses for exactly one cycle, CYCLES_PER_US cycles after `fuse_sel_n` rises and 11*CYCLES_PER_US cycles after it fell, with `req_data` equal to the fuse byte at `req_addr`.
- R9: A request made before `shadow_valid` is high is not acknowledged until after `shadow_valid` rises. Requests leave `version` and `leak_trim` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Single-byte read request, held until acknowledged |
| req_addr | input | 10 | Fuse address of the request |
| req_ack | output | 1 | One-cycle pulse: request done |
| req_data | output | 8 | Byte read for the last request |
| shadow_valid | output | 1 | Boot read of the shadow file is complete |
| version | output | 8 | Shadow entry 4 with bit 3 cleared |
| leak_sel | input | 2 | Leakage-trim channel index |
| leak_trim | output | 8 | Selected leakage-trim byte, 0 for index 3 |
| fuse_sel_n | output | 1 | Fuse array select, active low |
| fuse_load | output | 1 | Fuse array load (read mode) |
| fuse_strobe | output | 1 | Fuse array read strobe |
| fuse_pgm_n | output | 1 | Fuse array program enable, active low, held inactive |
| fuse_addr | output | 10 | Fuse array byte address |
| fuse_dout | input | 8 | Fuse array read data |

## Verification
A wrong interval counter or state code shows at the fuse pins within one session. Such faults appear as a strobe pulse or a guard gap that is off by cycles, a strobe outside the select window, or a skipped or repeated address. A fault in the byte counter or the write index shows only once the boot session completes: `shadow_valid` comes at the wrong cycle, or `version` and `leak_trim` return bytes from the wrong fuse addresses. A fault in request handling shows at the first acknowledge, as wrong data, a mistimed pulse, or an acknowledge given before the shadow file is valid.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_ADDR,
        ST_STROBE,
        ST_RELEASE,
        ST_TAIL,
        ST_CLOSE
    } fsr_state_e;

    typedef struct packed {
        logic sel_n;
        logic load;
        logic strobe;
        logic pgm_n;
    } fsr_pins_t;

endpackage

// File: rtl/fsr_seq.sv
module fsr_seq
    import fsr_pkg::*;
#(
    parameter int CYCLES_PER_US = 200,
    parameter int AW            = 10,
    parameter int DW            = 8,
    parameter int BOOT_BYTES    = 32,
    localparam int CW           = $clog2(2 * CYCLES_PER_US),
    localparam int LW           = $clog2(BOOT_BYTES + 1),
    localparam int IW           = $clog2(BOOT_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    output logic          req_ack,
    output logic [DW-1:0] req_data,
    output logic          shadow_valid,
    output logic          sh_we,
    output logic [IW-1:0] sh_idx,
    output logic [DW-1:0] sh_wdata,
    output fsr_pins_t     pins,
    output logic [AW-1:0] fuse_addr,
    input  logic [DW-1:0] fuse_dout
);

    localparam logic [CW-1:0] T_2US = CW'(2 * CYCLES_PER_US - 1);
    localparam logic [CW-1:0] T_1US = CW'(CYCLES_PER_US - 1);

    typedef struct packed {
        fsr_state_e    state;
        logic [CW-1:0] cnt;
        logic [AW-1:0] addr;
        logic [LW-1:0] left;
        logic          boot;
        logic          valid;
        logic          ack;
        logic [DW-1:0] rdata;
        logic          we;
        logic [IW-1:0] idx;
        logic [DW-1:0] wdata;
    } seq_t;

    seq_t q, d;
    logic tdone;

    assign tdone = (q.cnt == '0);

    always_comb begin
        d      = q;
        d.ack  = 1'b0;
        d.we   = 1'b0;
        if (q.state != ST_IDLE && !tdone) begin
            d.cnt = q.cnt - CW'(1);
        end
        unique case (q.state)
            ST_IDLE: begin
                if (!q.valid) begin
                    d.state = ST_SETUP;
                    d.cnt   = T_2US;
                    d.addr  = '0;
                    d.left  = LW'(BOOT_BYTES);
                    d.boot  = 1'b1;
                end else if (req_valid) begin
                    d.state = ST_SETUP;
                    d.cnt   = T_2US;
                    d.addr  = req_addr;
                    d.left  = LW'(1);
                    d.boot  = 1'b0;
                end
            end
            ST_SETUP: if (tdone) begin
                d.state = ST_ADDR;
                d.cnt   = T_2US;
            end
            ST_ADDR: if (tdone) begin
                d.state = ST_STROBE;
                d.cnt   = T_2US;
            end
            ST_STROBE: if (tdone) begin
                d.state = ST_RELEASE;
                d.cnt   = T_2US;
                if (q.boot) begin
                    d.we    = 1'b1;
                    d.idx   = q.addr[IW-1:0];
                    d.wdata = fuse_dout;
                end else begin
                    d.rdata = fuse_dout;
                end
            end
            ST_RELEASE: if (tdone) begin
                d.cnt = T_2US;
                if (q.left == LW'(1)) begin
                    d.state = ST_TAIL;
                end else begin
                    d.state = ST_ADDR;
                    d.left  = q.left - LW'(1);
                    d.addr  = q.addr + AW'(1);
                end
            end
            ST_TAIL: if (tdone) begin
                d.state = ST_CLOSE;
                d.cnt   = T_1US;
            end
            ST_CLOSE: if (tdone) begin
                d.state = ST_IDLE;
                if (q.boot) begin
                    d.valid = 1'b1;
                    d.boot  = 1'b0;
                end else begin
                    d.ack = 1'b1;
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    always_comb begin
        pins.sel_n  = (q.state == ST_IDLE) || (q.state == ST_CLOSE);
        pins.load   = !pins.sel_n;
        pins.strobe = (q.state == ST_STROBE);
        pins.pgm_n  = 1'b1;
        fuse_addr   = (q.state == ST_ADDR || q.state == ST_STROBE ||
                       q.state == ST_RELEASE) ? q.addr : '0;
    end

    assign req_ack      = q.ack;
    assign req_data     = q.rdata;
    assign shadow_valid = q.valid;
    assign sh_we        = q.we;
    assign sh_idx       = q.idx;
    assign sh_wdata     = q.wdata;

    assert_strobe_in_session_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pins.strobe |-> (!pins.sel_n && pins.load));

    assert_addr_stable_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pins.strobe && $past(pins.strobe)) |-> $stable(fuse_addr));

    assert_valid_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        shadow_valid |=> shadow_valid);

    assert_ack_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |=> !req_ack);

    assert_ack_after_boot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |-> shadow_valid);

    assert_shadow_write_boot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sh_we |-> !shadow_valid);

endmodule

// File: rtl/fsr_shadow.sv
module fsr_shadow #(
    parameter int DW         = 8,
    parameter int BYTES      = 32,
    parameter int VER_IDX    = 4,
    parameter int VER_MASKB  = 3,
    parameter int LEAK_BASE  = 23,
    parameter int LEAK_CH    = 3,
    localparam int IW        = $clog2(BYTES),
    localparam int SW        = $clog2(LEAK_CH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] idx,
    input  logic [DW-1:0] wdata,
    input  logic [SW-1:0] leak_sel,
    output logic [DW-1:0] version,
    output logic [DW-1:0] leak_trim
);

    logic [DW-1:0] mem_q [BYTES];
    logic [DW-1:0] mem_d [BYTES];

    always_comb begin
        for (int i = 0; i < BYTES; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (we) begin
            mem_d[idx] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < BYTES; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < BYTES; i++) begin
                mem_q[i] <= mem_d[i];
            end
        end
    end

    logic [DW-1:0] leak_vec [LEAK_CH];

    for (genvar c = 0; c < LEAK_CH; c++) begin : g_leak
        assign leak_vec[c] = mem_q[LEAK_BASE + c];
    end

    always_comb begin
        version            = mem_q[VER_IDX];
        version[VER_MASKB] = 1'b0;
        leak_trim          = '0;
        for (int c = 0; c < LEAK_CH; c++) begin
            if (int'(leak_sel) == c) begin
                leak_trim = leak_vec[c];
            end
        end
    end

endmodule

// File: rtl/fuse_shadow_reader.sv
module fuse_shadow_reader
    import fsr_pkg::*;
#(
    parameter int CYCLES_PER_US = 200,
    parameter int AW            = 10,
    parameter int DW            = 8,
    parameter int SHADOW_BYTES  = 32,
    parameter int LEAK_CH       = 3,
    localparam int IW           = $clog2(SHADOW_BYTES),
    localparam int SW           = $clog2(LEAK_CH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    output logic          req_ack,
    output logic [DW-1:0] req_data,
    output logic          shadow_valid,
    output logic [DW-1:0] version,
    input  logic [SW-1:0] leak_sel,
    output logic [DW-1:0] leak_trim,
    output logic          fuse_sel_n,
    output logic          fuse_load,
    output logic          fuse_strobe,
    output logic          fuse_pgm_n,
    output logic [AW-1:0] fuse_addr,
    input  logic [DW-1:0] fuse_dout
);

    fsr_pins_t     pins;
    logic          sh_we;
    logic [IW-1:0] sh_idx;
    logic [DW-1:0] sh_wdata;

    fsr_seq #(
        .CYCLES_PER_US(CYCLES_PER_US),
        .AW(AW),
        .DW(DW),
        .BOOT_BYTES(SHADOW_BYTES)
    ) u_seq (
        .clk(clk),
        .rst_n(rst_n),
        .req_valid(req_valid),
        .req_addr(req_addr),
        .req_ack(req_ack),
        .req_data(req_data),
        .shadow_valid(shadow_valid),
        .sh_we(sh_we),
        .sh_idx(sh_idx),
        .sh_wdata(sh_wdata),
        .pins(pins),
        .fuse_addr(fuse_addr),
        .fuse_dout(fuse_dout)
    );

    fsr_shadow #(
        .DW(DW),
        .BYTES(SHADOW_BYTES),
        .LEAK_CH(LEAK_CH)
    ) u_shadow (
        .clk(clk),
        .rst_n(rst_n),
        .we(sh_we),
        .idx(sh_idx),
        .wdata(sh_wdata),
        .leak_sel(leak_sel),
        .version(version),
        .leak_trim(leak_trim)
    );

    assign fuse_sel_n  = pins.sel_n;
    assign fuse_load   = pins.load;
    assign fuse_strobe = pins.strobe;
    assign fuse_pgm_n  = pins.pgm_n;

endmodule

// File: tb/fuse_shadow_reader_tb.sv
module fuse_shadow_reader_tb;

    localparam int CPU = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [9:0] req_addr = '0;
    logic       req_ack;
    logic [7:0] req_data;
    logic       shadow_valid;
    logic [7:0] version;
    logic [1:0] leak_sel = '0;
    logic [7:0] leak_trim;
    logic       fuse_sel_n, fuse_load, fuse_strobe, fuse_pgm_n;
    logic [9:0] fuse_addr;
    logic [7:0] fuse_dout;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    function automatic logic [7:0] fmodel(input logic [9:0] a);
        return (a[7:0] * 8'd29) ^ {6'b0, a[9:8]} ^ 8'h5A;
    endfunction

    assign fuse_dout = (!fuse_sel_n && fuse_load && fuse_strobe) ? fmodel(fuse_addr) : 8'h00;

    fuse_shadow_reader #(.CYCLES_PER_US(CPU)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_addr(req_addr),
        .req_ack(req_ack), .req_data(req_data),
        .shadow_valid(shadow_valid), .version(version),
        .leak_sel(leak_sel), .leak_trim(leak_trim),
        .fuse_sel_n(fuse_sel_n), .fuse_load(fuse_load),
        .fuse_strobe(fuse_strobe), .fuse_pgm_n(fuse_pgm_n),
        .fuse_addr(fuse_addr), .fuse_dout(fuse_dout)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Pin monitor: timing and address order of every session
    int   cyc = 0;
    int   t_sel_fall = 0, t_sel_rise = 0, t_stb_rise = 0, t_stb_fall = 0;
    bit   p_sel_n = 1'b1, p_stb = 1'b0, p_valid = 1'b0, p_ack = 1'b0;
    bit   first_stb = 1'b0, sess_boot = 1'b0;
    int   boot_strobes = 0;
    logic [9:0] last_addr = '0, rise_addr = '0, cur_req = '0;

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (p_sel_n && !fuse_sel_n) begin
                t_sel_fall = cyc;
                first_stb  = 1'b1;
                sess_boot  = !shadow_valid;
                check(fuse_load == 1'b1, "R2 load with select", int'(fuse_load), 1);
            end
            if (!p_stb && fuse_strobe) begin
                check(!fuse_sel_n && fuse_load, "R2 strobe inside session", int'(fuse_sel_n), 0);
                if (first_stb) begin
                    check(cyc - t_sel_fall == 4 * CPU, "R2 select to first strobe",
                          cyc - t_sel_fall, 4 * CPU);
                    check(fuse_addr == (sess_boot ? 10'd0 : cur_req), "R3 first address",
                          int'(fuse_addr), sess_boot ? 0 : int'(cur_req));
                end else begin
                    check(cyc - t_stb_fall == 4 * CPU, "R3 gap between strobes",
                          cyc - t_stb_fall, 4 * CPU);
                    check(fuse_addr == last_addr + 10'd1, "R3 address increments",
                          int'(fuse_addr), int'(last_addr) + 1);
                end
                first_stb  = 1'b0;
                t_stb_rise = cyc;
                rise_addr  = fuse_addr;
                if (sess_boot) boot_strobes++;
            end
            if (p_stb && fuse_strobe) begin
                check(fuse_addr == rise_addr, "R3 address stable in strobe",
                      int'(fuse_addr), int'(rise_addr));
            end
            if (p_stb && !fuse_strobe) begin
                check(cyc - t_stb_rise == 2 * CPU, "R3 strobe width",
                      cyc - t_stb_rise, 2 * CPU);
                t_stb_fall = cyc;
                last_addr  = rise_addr;
            end
            if (!p_sel_n && fuse_sel_n) begin
                t_sel_rise = cyc;
                check(cyc - t_stb_fall == 4 * CPU, "R4 last strobe to deselect",
                      cyc - t_stb_fall, 4 * CPU);
            end
            if (!p_valid && shadow_valid) begin
                check(cyc - t_sel_fall == 197 * CPU, "R5 boot duration",
                      cyc - t_sel_fall, 197 * CPU);
                check(boot_strobes == 32, "R5 boot byte count", boot_strobes, 32);
            end
            if (p_valid && !shadow_valid) begin
                check(1'b0, "R5 valid stays high", 0, 1);
            end
            if (!p_ack && req_ack) begin
                check(cyc - t_sel_rise == CPU, "R4 close interval", cyc - t_sel_rise, CPU);
                check(cyc - t_sel_fall == 11 * CPU, "R8 request session length",
                      cyc - t_sel_fall, 11 * CPU);
            end
            if (p_ack && req_ack) begin
                check(1'b0, "R8 ack single cycle", 1, 0);
            end
            if (!fuse_pgm_n) begin
                check(1'b0, "R1 program enable inactive", 0, 1);
            end
        end
        p_sel_n = fuse_sel_n;
        p_stb   = fuse_strobe;
        p_valid = shadow_valid;
        p_ack   = req_ack;
    end

    task automatic t_reset();
        @(negedge clk);
        check(fuse_sel_n == 1'b1, "R1 select idle", int'(fuse_sel_n), 1);
        check(fuse_load == 1'b0 && fuse_strobe == 1'b0, "R1 load/strobe idle",
              int'({fuse_load, fuse_strobe}), 0);
        check(fuse_pgm_n == 1'b1 && fuse_addr == '0, "R1 pgm/addr idle",
              int'(fuse_addr), 0);
        check(shadow_valid == 1'b0 && req_ack == 1'b0, "R1 valid/ack low",
              int'({shadow_valid, req_ack}), 0);
    endtask

    task automatic do_request(input logic [9:0] a, input string tag);
        int wait_cyc = 0;
        bit early = 1'b0;
        @(negedge clk);
        req_addr  = a;
        cur_req   = a;
        req_valid = 1'b1;
        while (!req_ack && wait_cyc < 20000) begin
            @(negedge clk);
            wait_cyc++;
        end
        if (req_ack && !shadow_valid) early = 1'b1;
        check(req_ack == 1'b1, {tag, " ack seen"}, int'(req_ack), 1);
        check(!early, "R9 ack not before valid", int'(early), 0);
        check(req_data == fmodel(a), {tag, " data"}, int'(req_data), int'(fmodel(a)));
        req_valid = 1'b0;
    endtask

    task automatic t_boot_holdoff();
        // R9: request issued right after reset, before the boot read
        @(negedge clk);
        check(shadow_valid == 1'b0, "R9 boot still running", int'(shadow_valid), 0);
        do_request(10'h155, "R9 held request");
    endtask

    task automatic t_shadow_outputs();
        logic [7:0] exp_ver;
        exp_ver = fmodel(10'd4) & 8'hF7;
        @(negedge clk);
        check(version == exp_ver, "R6 version bit3 cleared", int'(version), int'(exp_ver));
        for (int c = 0; c < 3; c++) begin
            leak_sel = 2'(c);
            @(negedge clk);
            check(leak_trim == fmodel(10'(23 + c)), "R7 leakage channel",
                  int'(leak_trim), int'(fmodel(10'(23 + c))));
        end
        leak_sel = 2'd3;
        @(negedge clk);
        check(leak_trim == 8'h00, "R7 channel 3 zero", int'(leak_trim), 0);
    endtask

    task automatic t_requests();
        do_request(10'd0, "R8 addr 0");
        do_request(10'd4, "R8 addr 4");
        do_request(10'h3FF, "R8 top addr");
        do_request(10'h2A7, "R8 mid addr");
    endtask

    task automatic t_shadow_unchanged();
        logic [7:0] exp_ver;
        exp_ver = fmodel(10'd4) & 8'hF7;
        leak_sel = 2'd1;
        @(negedge clk);
        check(version == exp_ver, "R9 version unchanged", int'(version), int'(exp_ver));
        check(leak_trim == fmodel(10'd24), "R9 leakage unchanged",
              int'(leak_trim), int'(fmodel(10'd24)));
    endtask

    initial begin
        repeat (3) t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_boot_holdoff();
        t_shadow_outputs();
        t_requests();
        t_shadow_unchanged();
        repeat (20) @(negedge clk);
        check(fuse_sel_n && !fuse_load && fuse_addr == '0, "R1 idle after sessions",
              int'(fuse_sel_n), 1);
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule